// File: doc/BRIEF.md
# Descriptor-Chained Scatter-Gather DMA Sequencer

This block moves 32-bit words between a card-side data FIFO and system memory. It can work on one contiguous buffer, or follow a chain of three-word descriptors held in memory. Each descriptor names a buffer. Its link word carries update flags that decide which of the following words the engine reloads. The chain ends at the element whose link-update flag is clear. There is no null-pointer terminator.

Software loads a descriptor-area base, a first link word, a first buffer base and a first buffer size, then writes the control word. Before it moves any data for an element, the sequencer checks that element. The buffer base must sit on a 32-bit boundary. Unless the element is the last one, the size must be a multiple of a configured granularity. A failed check raises a sticky error and stops the engine. A simple request/acknowledge port is used for both descriptor reads and data beats. A valid/ready stream connects the engine to the FIFO.

Top module: `sg_chain_dma`

## Requirements
- R1: After reset, `busy`, `done` and `xfer_err` are low and `mem_req` stays low until a start is written.
- R2: A control write with bit 0 (enable) set and bit 1 (chain) clear runs single-buffer mode. The engine moves ceil(size/4) words to consecutive word addresses starting at the first base, and ignores the link word. A size of 0 moves nothing and still completes.
- R3: Descriptors are fetched with reads at area base + offset. The link word is at +0, the buffer base at +4 and the size at +8. In a link word, bit 31 is link-update, bit 30 is size-update and bits [15:0] are the byte offset of the next descriptor from the area base. The fetch address is held until it is acknowledged.
- R4: The element whose link word has bit 31 clear is the last one. When its bytes are all moved, the engine raises `done` and drops `busy`.
- R5: When a fetched link word has bit 30 clear, only its link and base words are read, and the previous size is kept.
- R6: The final beat of a buffer enables only the low (size mod 4) byte lanes (lane 0 = data bits [7:0]). A size that is a multiple of 4 gives all four lanes.
- R7: A buffer base with bits [1:0] not zero, whether initial or fetched, sets the sticky `xfer_err` and stops the engine with no data beat for that buffer. Earlier buffers in the chain are still moved.
- R8: A buffer size that is not a multiple of 2^GRAN_LSB bytes (8 by default) is an error for every element except the last. The last element may have any size.
- R9: A control write with bit 0 clear while busy makes the engine finish the current buffer and then go idle. It fetches no further descriptor and leaves `done` low.
- R10: With control bit 2 set, FIFO words are written to memory in arrival order. With it clear, memory words are read and presented on the FIFO output in address order.
- R11: A start write is ignored while busy. A start accepted when idle clears `done` and `xfer_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit 0 enable, bit 1 chain, bit 2 to-memory |
| cfg_area_base | input | 32 | Descriptor-area base address |
| cfg_link0 | input | 32 | First link word |
| cfg_base0 | input | 32 | First buffer base |
| cfg_size0 | input | SIZE_W | First buffer size in bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_in_valid | input | 1 | FIFO word available for memory write |
| fifo_in_data | input | 32 | FIFO word |
| fifo_in_ready | output | 1 | FIFO word consumed |
| fifo_out_valid | output | 1 | Word read from memory for the FIFO |
| fifo_out_data | output | 32 | Word for the FIFO |
| fifo_out_ready | input | 1 | FIFO can take a word (held while a read is pending) |
| busy | output | 1 | Engine running |
| done | output | 1 | Last buffer fully moved |
| xfer_err | output | 1 | Sticky alignment or size error |

## Verification
The bench targets a descriptor whose size-update flag is clear. A design that fetched the size anyway would load the junk value planted there and write far too many words. It checks mid-chain alignment faults, where a wrong design either drops the already-moved first buffer or writes to the odd address. It also checks a stop request given early in a long buffer. Here a wrong design either cuts the buffer short or walks on into the next descriptor. Partial final words and zero-length buffers expose off-by-one errors in the byte countdown and in lane masking.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

  localparam int LNK_UPD_BIT = 31;
  localparam int SZ_UPD_BIT  = 30;
  localparam int CTL_EN      = 0;
  localparam int CTL_CHAIN   = 1;
  localparam int CTL_TOMEM   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MOVE,
    ST_GET_LINK,
    ST_GET_BASE,
    ST_GET_SIZE
  } seq_state_e;

  // byte lanes for a beat with rem bytes still owed
  function automatic logic [3:0] lane_mask(input logic [31:0] rem);
    if (rem >= 32'd4) return 4'hF;
    case (rem[1:0])
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  // next descriptor address: area base plus word-aligned offset field
  function automatic logic [31:0] desc_addr(input logic [31:0] area,
                                            input logic [31:0] link,
                                            input int          off_w);
    logic [31:0] off;
    off = '0;
    for (int i = 2; i < 32; i++)
      if (i < off_w) off[i] = link[i];
    return area + off;
  endfunction

  // size is a whole number of granules of 2**lsb bytes
  function automatic logic size_granular(input logic [31:0] sz, input int lsb);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 32; i++)
      if (i < lsb && sz[i]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/sg_dma_check.sv
module sg_dma_check #(
  parameter int GRAN_LSB = 3
) (
  input  logic [31:0] base,
  input  logic [31:0] size,
  input  logic        is_last,
  output logic        bad_base,
  output logic        bad_size,
  output logic        fail
);
  import sg_dma_pkg::*;

  always_comb begin
    bad_base = (base[1:0] != 2'b00);
    bad_size = !is_last && !size_granular(size, GRAN_LSB);
    fail     = bad_base || bad_size;
  end

endmodule

// File: rtl/sg_dma_beat.sv
module sg_dma_beat #(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [31:0]       ld_base,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              advance,
  output logic [31:0]       beat_addr,
  output logic [3:0]        beat_be,
  output logic              empty
);
  import sg_dma_pkg::*;

  localparam logic [SIZE_W-1:0] WORD_STEP = SIZE_W'(4);

  logic [31:0]       addr_q;
  logic [SIZE_W-1:0] rem_q;
  logic [SIZE_W-1:0] step;

  assign step      = (rem_q >= WORD_STEP) ? WORD_STEP : rem_q;
  assign beat_addr = addr_q;
  assign beat_be   = lane_mask(32'(rem_q));
  assign empty     = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= ld_base;
      rem_q  <= ld_size;
    end else if (advance && !empty) begin
      addr_q <= addr_q + 32'd4;
      rem_q  <= rem_q - step;
    end
  end

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !load |=> empty); // R2
  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> beat_addr[1:0] == 2'b00); // R7

endmodule

// File: rtl/sg_dma_seq.sv
module sg_dma_seq #(
  parameter int SIZE_W = 16,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic [31:0]       cfg_area_base,
  input  logic [31:0]       cfg_link0,
  input  logic [31:0]       cfg_base0,
  input  logic [SIZE_W-1:0] cfg_size0,
  input  logic              chk_fail,
  output logic [31:0]       cur_base,
  output logic [SIZE_W-1:0] cur_size,
  output logic              cur_last,
  input  logic [31:0]       beat_addr,
  input  logic [3:0]        beat_be,
  input  logic              beat_empty,
  output logic              beat_load,
  output logic              beat_advance,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              fifo_in_valid,
  input  logic [31:0]       fifo_in_data,
  output logic              fifo_in_ready,
  output logic              fifo_out_valid,
  output logic [31:0]       fifo_out_data,
  input  logic              fifo_out_ready,
  output logic              busy,
  output logic              done,
  output logic              xfer_err
);
  import sg_dma_pkg::*;

  seq_state_e  state;
  logic        chain_q, tomem_q, stop_q;
  logic [31:0] area_q, cur_link, desc_ptr;
  logic [31:0] fetch_addr;

  // named internal events
  logic start_go, stop_hit, in_fetch, move_req, elem_end, last_fin;

  assign start_go = ctl_wr && ctl_wdata[CTL_EN] && (state == ST_IDLE);
  assign stop_hit = ctl_wr && !ctl_wdata[CTL_EN] && (state != ST_IDLE);
  assign in_fetch = (state == ST_GET_LINK) || (state == ST_GET_BASE) ||
                    (state == ST_GET_SIZE);
  assign move_req = (state == ST_MOVE) && !beat_empty &&
                    (tomem_q ? fifo_in_valid : fifo_out_ready);
  assign elem_end = (state == ST_MOVE) && beat_empty;
  assign cur_last = !chain_q || !cur_link[LNK_UPD_BIT];
  assign last_fin = elem_end && !stop_q && cur_last;

  always_comb begin
    case (state)
      ST_GET_BASE: fetch_addr = desc_ptr + 32'd4;
      ST_GET_SIZE: fetch_addr = desc_ptr + 32'd8;
      default:     fetch_addr = desc_ptr;
    endcase
  end

  assign mem_req        = in_fetch || move_req;
  assign mem_we         = (state == ST_MOVE) && tomem_q;
  assign mem_addr       = in_fetch ? fetch_addr : beat_addr;
  assign mem_be         = in_fetch ? 4'hF : beat_be;
  assign mem_wdata      = fifo_in_data;
  assign beat_load      = (state == ST_CHECK) && !chk_fail;
  assign beat_advance   = move_req && mem_ack;
  assign fifo_in_ready  = move_req && mem_ack && tomem_q;
  assign fifo_out_valid = move_req && mem_ack && !tomem_q;
  assign fifo_out_data  = mem_rdata;
  assign busy           = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      chain_q  <= 1'b0;
      tomem_q  <= 1'b0;
      stop_q   <= 1'b0;
      area_q   <= '0;
      cur_link <= '0;
      cur_base <= '0;
      cur_size <= '0;
      desc_ptr <= '0;
      done     <= 1'b0;
      xfer_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_go) begin
          chain_q  <= ctl_wdata[CTL_CHAIN];
          tomem_q  <= ctl_wdata[CTL_TOMEM];
          area_q   <= cfg_area_base;
          cur_link <= cfg_link0;
          cur_base <= cfg_base0;
          cur_size <= cfg_size0;
          stop_q   <= 1'b0;
          done     <= 1'b0;
          xfer_err <= 1'b0;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_fail) begin
            xfer_err <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            state    <= ST_MOVE;
          end
        end
        ST_MOVE: if (beat_empty) begin
          if (stop_q) begin
            state <= ST_IDLE;
          end else if (cur_last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            desc_ptr <= desc_addr(area_q, cur_link, OFF_W);
            state    <= ST_GET_LINK;
          end
        end
        ST_GET_LINK: if (mem_ack) begin
          cur_link <= mem_rdata;
          state    <= ST_GET_BASE;
        end
        ST_GET_BASE: if (mem_ack) begin
          cur_base <= mem_rdata;
          state    <= cur_link[SZ_UPD_BIT] ? ST_GET_SIZE : ST_CHECK;
        end
        ST_GET_SIZE: if (mem_ack) begin
          cur_size <= mem_rdata[SIZE_W-1:0];
          state    <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
      if (stop_hit) stop_q <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> !mem_we); // R3
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_fin)); // R4
  AST_FAIL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) && chk_fail |=> !mem_req && !busy); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err && !start_go |=> xfer_err); // R7
  AST_STOP_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && elem_end |=> !busy && !done); // R9

endmodule

// File: rtl/sg_chain_dma.sv
module sg_chain_dma #(
  parameter int SIZE_W   = 16,
  parameter int OFF_W    = 16,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic [31:0]       cfg_area_base,
  input  logic [31:0]       cfg_link0,
  input  logic [31:0]       cfg_base0,
  input  logic [SIZE_W-1:0] cfg_size0,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              fifo_in_valid,
  input  logic [31:0]       fifo_in_data,
  output logic              fifo_in_ready,
  output logic              fifo_out_valid,
  output logic [31:0]       fifo_out_data,
  input  logic              fifo_out_ready,
  output logic              busy,
  output logic              done,
  output logic              xfer_err
);

  logic              chk_fail, bad_base, bad_size;
  logic [31:0]       cur_base;
  logic [SIZE_W-1:0] cur_size;
  logic              cur_last;
  logic [31:0]       beat_addr;
  logic [3:0]        beat_be;
  logic              beat_empty, beat_load, beat_advance;

  sg_dma_check #(.GRAN_LSB(GRAN_LSB)) u_check (
    .base     (cur_base),
    .size     (32'(cur_size)),
    .is_last  (cur_last),
    .bad_base (bad_base),
    .bad_size (bad_size),
    .fail     (chk_fail)
  );

  sg_dma_beat #(.SIZE_W(SIZE_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (beat_load),
    .ld_base   (cur_base),
    .ld_size   (cur_size),
    .advance   (beat_advance),
    .beat_addr (beat_addr),
    .beat_be   (beat_be),
    .empty     (beat_empty)
  );

  sg_dma_seq #(.SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_wr         (ctl_wr),
    .ctl_wdata      (ctl_wdata),
    .cfg_area_base  (cfg_area_base),
    .cfg_link0      (cfg_link0),
    .cfg_base0      (cfg_base0),
    .cfg_size0      (cfg_size0),
    .chk_fail       (chk_fail),
    .cur_base       (cur_base),
    .cur_size       (cur_size),
    .cur_last       (cur_last),
    .beat_addr      (beat_addr),
    .beat_be        (beat_be),
    .beat_empty     (beat_empty),
    .beat_load      (beat_load),
    .beat_advance   (beat_advance),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_be         (mem_be),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata),
    .fifo_in_valid  (fifo_in_valid),
    .fifo_in_data   (fifo_in_data),
    .fifo_in_ready  (fifo_in_ready),
    .fifo_out_valid (fifo_out_valid),
    .fifo_out_data  (fifo_out_data),
    .fifo_out_ready (fifo_out_ready),
    .busy           (busy),
    .done           (done),
    .xfer_err       (xfer_err)
  );

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_err) |-> $past(bad_base || bad_size)); // R8

endmodule

// File: tb/tb_sg_chain_dma.sv
module tb_sg_chain_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [31:0] cfg_area_base = '0, cfg_link0 = '0, cfg_base0 = '0;
  logic [15:0] cfg_size0 = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        fifo_in_valid = 1'b1;
  logic [31:0] fifo_in_data;
  logic        fifo_in_ready, fifo_out_valid;
  logic [31:0] fifo_out_data;
  logic        fifo_out_ready = 1'b1;
  logic        busy, done, xfer_err;

  always #5 clk = ~clk;

  sg_chain_dma dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cfg_area_base(cfg_area_base), .cfg_link0(cfg_link0),
    .cfg_base0(cfg_base0), .cfg_size0(cfg_size0),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_in_valid(fifo_in_valid), .fifo_in_data(fifo_in_data),
    .fifo_in_ready(fifo_in_ready), .fifo_out_valid(fifo_out_valid),
    .fifo_out_data(fifo_out_data), .fifo_out_ready(fifo_out_ready),
    .busy(busy), .done(done), .xfer_err(xfer_err)
  );

  // memory model, logs and FIFO ends
  logic [31:0] mem [256];
  logic [31:0] wr_addr_log [128];
  logic [3:0]  wr_be_log   [128];
  logic [31:0] wr_dat_log  [128];
  logic [31:0] rd_addr_log [128];
  logic [31:0] out_log     [128];
  int wr_cnt = 0, rd_cnt = 0, out_cnt = 0;
  logic [31:0] src_data;
  assign fifo_in_data = src_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      src_data  <= 32'h5000_0000;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 | 32'(i);
      mem[8'h80] <= 32'h8000_000C; mem[8'h81] <= 32'h0000_0340; mem[8'h82] <= 32'h0000_DEAD;
      mem[8'h83] <= 32'h4000_0000; mem[8'h84] <= 32'h0000_0380; mem[8'h85] <= 32'h0000_0006;
      mem[8'h88] <= 32'h0000_0000; mem[8'h89] <= 32'h0000_03A2; mem[8'h8A] <= 32'h0000_0004;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          wr_addr_log[wr_cnt[6:0]] <= mem_addr;
          wr_be_log[wr_cnt[6:0]]   <= mem_be;
          wr_dat_log[wr_cnt[6:0]]  <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_addr_log[rd_cnt[6:0]] <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (fifo_in_valid && fifo_in_ready) src_data <= src_data + 32'd1;
      if (fifo_out_valid && fifo_out_ready) begin
        out_log[out_cnt[6:0]] <= fifo_out_data;
        out_cnt <= out_cnt + 1;
      end
    end
  end

  int total = 0, bad = 0, cycles = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] ctl, input logic [31:0] area,
                       input logic [31:0] link, input logic [31:0] base,
                       input logic [15:0] size);
    @(negedge clk);
    cfg_area_base = area; cfg_link0 = link; cfg_base0 = base; cfg_size0 = size;
    ctl_wdata = ctl; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [2:0] ctl);
    ctl_wdata = ctl; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [3:0] exp_last_be(input logic [15:0] sz);
    logic [3:0] m;
    m = 4'hF;
    if (sz % 4 == 1) m = 4'b0001;
    if (sz % 4 == 2) m = 4'b0011;
    if (sz % 4 == 3) m = 4'b0111;
    return m;
  endfunction

  // single-buffer to-memory vectors: {base[15:0], size[15:0], expect_err}
  localparam logic [32:0] TV [6] = '{
    {16'h0100, 16'd8,  1'b0},
    {16'h0104, 16'd5,  1'b0},
    {16'h0102, 16'd4,  1'b1},
    {16'h0140, 16'd14, 1'b0},
    {16'h0180, 16'd0,  1'b0},
    {16'h01C1, 16'd3,  1'b1}
  };

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int w0, r0, o0, n;
    logic [15:0] sz;
    logic [31:0] bs;
    logic        e;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "busy", 32'(busy), 0);
    check("R1", "done", 32'(done), 0);
    check("R1", "err", 32'(xfer_err), 0);
    check("R1", "mem_req", 32'(mem_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "mem_req idle", 32'(mem_req), 0);

    // R2 R6 R7 R10 R11 table: single mode, FIFO to memory
    for (int i = 0; i < 6; i++) begin
      bs = 32'(TV[i][32:17]); sz = TV[i][16:1]; e = TV[i][0];
      n  = e ? 0 : (int'(sz) + 3) / 4;
      w0 = wr_cnt;
      start(3'b101, 32'h0, 32'hC000_0000, bs, sz);
      wait_idle();
      check("R2", "beat count", 32'(wr_cnt - w0), 32'(n));
      check("R7", "err flag", 32'(xfer_err), 32'(e));   // also R11: cleared on start
      check("R2", "done", 32'(done), 32'(!e));
      if (n > 0) begin
        check("R2", "first addr", wr_addr_log[w0], bs);
        check("R2", "last addr", wr_addr_log[w0+n-1], bs + 32'(4*(n-1)));
        check("R6", "last lanes", 32'(wr_be_log[w0+n-1]), 32'(exp_last_be(sz)));
        check("R10", "arrival order", wr_dat_log[w0+n-1] - wr_dat_log[w0], 32'(n-1));
      end
    end

    // R10 memory to FIFO direction
    o0 = out_cnt; r0 = rd_cnt;
    start(3'b001, 32'h0, 32'h0, 32'h10, 16'd12);
    wait_idle();
    check("R10", "out count", 32'(out_cnt - o0), 3);
    check("R10", "out word0", out_log[o0], 32'hA000_0004);
    check("R10", "out word2", out_log[o0+2], 32'hA000_0006);
    check("R10", "read count", 32'(rd_cnt - r0), 3);

    // R3 R4 R5 R6 three-element chain, middle link keeps size
    w0 = wr_cnt; r0 = rd_cnt;
    start(3'b111, 32'h200, 32'hC000_0000, 32'h300, 16'd8);
    wait_idle();
    check("R4", "done", 32'(done), 1);
    check("R4", "err", 32'(xfer_err), 0);
    check("R5", "writes kept size", 32'(wr_cnt - w0), 6);
    check("R5", "desc reads", 32'(rd_cnt - r0), 5);
    check("R3", "read0", rd_addr_log[r0], 32'h200);
    check("R3", "read1", rd_addr_log[r0+1], 32'h204);
    check("R3", "read2 next desc", rd_addr_log[r0+2], 32'h20C);
    check("R3", "read4 size", rd_addr_log[r0+4], 32'h214);
    check("R3", "elem2 addr", wr_addr_log[w0+2], 32'h340);
    check("R3", "elem3 addr", wr_addr_log[w0+5], 32'h384);
    check("R6", "chain last lanes", 32'(wr_be_log[w0+5]), 32'h3);

    // R8 non-last size not granular
    w0 = wr_cnt; r0 = rd_cnt;
    start(3'b111, 32'h200, 32'h8000_0000, 32'h300, 16'd6);
    wait_idle();
    check("R8", "err", 32'(xfer_err), 1);
    check("R8", "no writes", 32'(wr_cnt - w0), 0);
    check("R8", "no reads", 32'(rd_cnt - r0), 0);

    // R7 misaligned fetched base mid-chain
    w0 = wr_cnt; r0 = rd_cnt;
    start(3'b111, 32'h200, 32'h8000_0020, 32'h300, 16'd8);
    wait_idle();
    check("R7", "mid err", 32'(xfer_err), 1);
    check("R7", "first buffer moved", 32'(wr_cnt - w0), 2);
    check("R7", "link+base reads", 32'(rd_cnt - r0), 2);
    check("R7", "no done", 32'(done), 0);

    // R9 stop while busy
    w0 = wr_cnt; r0 = rd_cnt;
    start(3'b111, 32'h200, 32'hC000_0000, 32'h300, 16'd16);
    ctl_write(3'b000);
    wait_idle();
    check("R9", "buffer finished", 32'(wr_cnt - w0), 4);
    check("R9", "no fetch", 32'(rd_cnt - r0), 0);
    check("R9", "done low", 32'(done), 0);

    // R11 start ignored while busy
    w0 = wr_cnt;
    start(3'b101, 32'h0, 32'h0, 32'h100, 16'd16);
    cfg_base0 = 32'h180; cfg_size0 = 16'd4;
    ctl_write(3'b101);
    wait_idle();
    check("R11", "writes", 32'(wr_cnt - w0), 4);
    check("R11", "last addr", wr_addr_log[w0+3], 32'h10C);
    check("R11", "done", 32'(done), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule